// File: doc/BRIEF.md
# ADC Sequence Control and Conversion Flag Logic

This block is the digital front end of a successive-approximation converter. It holds one bus-writable control byte. The byte covers converter power, a choice between two flag-clear policies, power-down during wait mode, and trigger enable, sensitivity and polarity. It also holds an interrupt enable and a sequence-complete flag. An external trigger pin goes through a two-flop synchronizer and then an edge or level qualifier. A qualified trigger starts a conversion sequence, but only when the converter is powered, has finished its recovery delay and is idle.

The converter reports each finished conversion as a one-cycle `conv_done` pulse with a channel index. The block counts `SEQ_LEN` accepted conversions per sequence and raises a per-channel conversion-complete flag for each one. It raises the sequence flag on the last one. Software clears channel flags through result reads under one of two policies, selected by a control bit. Any write to the control byte abandons a running sequence and never starts one. In wait mode, when the control byte requests it, the converter is powered down and the sequence is frozen. The first result taken after wake-up is marked unreliable.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata`, `ccf`, `irq`, `conv_pwr` and `suspect` are all 0.
- R2: A control write while a sequence runs pulses `seq_abort` in that cycle and ends the sequence. The write itself starts no sequence, and later `conv_done` pulses set no flags until a new start.
- R3: With bit 7 (power) at 0, `conv_pwr` is 0 and `seq_start` never asserts.
- R4: After power rises, triggers are ignored until `REC_CYC` (default 16) clock cycles have passed. Triggers after that delay start sequences.
- R5: With bit 2 (trigger enable) at 0, no trigger activity starts a sequence.
- R6: With bit 4 at 0 (edge mode), each synchronized transition of `trig_in` to the active polarity gives exactly one `seq_start`. Bit 3 at 1 selects rising edges and bit 3 at 0 selects falling edges. The opposite transition starts nothing.
- R7: With bit 4 at 1 (level mode), a sequence starts on every idle, ready cycle while `trig_in` is at the active level. Bit 3 at 1 makes high the active level and bit 3 at 0 makes low the active level.
- R8: A sequence accepts `SEQ_LEN` (default 4) `conv_done` pulses. Each accepted pulse sets `ccf[conv_ch]`. The last one sets bit 0 of `ctl_rdata` (the sequence flag) and ends the sequence.
- R9: With bit 6 at 0, a `res_rd` of channel k clears `ccf[k]` only if a `stat_rd` happened while `ccf[k]` was set and no result read of k came in between. A result read with no prior status read leaves the flag set.
- R10: With bit 6 at 1, any `res_rd` of channel k clears `ccf[k]`, with no status read needed.
- R11: With bit 5 at 1, `wait_mode` drives `conv_pwr` to 0 and `conv_done` is ignored, while the sequence is kept. After wait mode ends, the first accepted result sets `suspect` to 1, and the next accepted result returns it to 0.
- R12: With bit 5 at 0, `wait_mode` has no effect: `conv_pwr` stays 1 and conversions are accepted.
- R13: `irq` is bit 1 AND the sequence flag. Writing 1 to bit 0 clears the flag, and writing 0 to bit 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Control byte write strobe |
| bus_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback, bit 0 is the sequence flag |
| stat_rd | input | 1 | Status register read strobe |
| res_rd | input | 1 | Result register read strobe |
| res_idx | input | CH_W | Channel of the result read |
| wait_mode | input | 1 | System wait mode |
| trig_in | input | 1 | Asynchronous external trigger |
| conv_done | input | 1 | Conversion finished pulse from the converter |
| conv_ch | input | CH_W | Channel of the finished conversion |
| conv_pwr | output | 1 | Converter analog power enable |
| seq_start | output | 1 | One-cycle sequence start |
| seq_abort | output | 1 | One-cycle sequence abort |
| ccf | output | NCH | Per-channel conversion-complete flags |
| suspect | output | 1 | Most recent accepted result is unreliable |
| irq | output | 1 | Sequence-complete interrupt request |

## Verification
The assertions assume that `conv_done` and the bus strobes are single-cycle pulses. They also assume that `conv_ch` and `res_idx` stay below `NCH`, and that the converter only reports conversions between a start and the end of that sequence. The bench drives every strobe for exactly one cycle at the falling edge and uses only channels 0 to 7. It emits converter pulses only after it has seen `seq_start`, with the one exception of the deliberate post-abort pulses that check R2. It changes `trig_in` only at falling edges and holds each level for several cycles, so the synchronizer never sees a sub-cycle pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CB_PWR  = 7;
  localparam int CB_FAST = 6;
  localparam int CB_WOFF = 5;
  localparam int CB_LVL  = 4;
  localparam int CB_POL  = 3;
  localparam int CB_TEN  = 2;
  localparam int CB_IEN  = 1;

  function automatic logic trig_hit(input logic level_mode, input logic act_high,
                                    input logic cur, input logic prev);
    logic cur_act, prev_act;
    cur_act  = (cur == act_high);
    prev_act = (prev == act_high);
    return level_mode ? cur_act : (cur_act && !prev_act);
  endfunction

  function automatic logic [31:0] rec_step(input logic [31:0] cnt, input logic on,
                                           input logic [31:0] lim);
    if (!on) return 32'd0;
    if (cnt >= lim) return lim;
    return cnt + 32'd1;
  endfunction

endpackage

// File: rtl/adc_trig_cond.sv
module adc_trig_cond
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic enable,
  input  logic level_mode,
  input  logic act_high,
  output logic req
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign req = enable && trig_hit(level_mode, act_high, s2_q, s3_q);

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !level_mode) |=> (!req || level_mode));

endmodule

// File: rtl/adc_pwr_recov.sv
module adc_pwr_recov
  import adc_seq_pkg::*;
#(
  parameter int REC_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic ready
);
  localparam int REC_W = $clog2(REC_CYC + 1);

  logic [REC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= REC_W'(rec_step(32'(cnt_q), pwr_on, 32'(REC_CYC)));
  end

  assign ready = pwr_on && (cnt_q == REC_W'(REC_CYC));

  // R4
  recov_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !ready);

endmodule

// File: rtl/adc_ccf_bank.sv
module adc_ccf_bank #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast,
  input  logic            set_en,
  input  logic [CH_W-1:0] set_idx,
  input  logic            stat_rd,
  input  logic            res_rd,
  input  logic [CH_W-1:0] res_idx,
  output logic [NCH-1:0]  ccf
);
  logic [NCH-1:0] ccf_q, armed_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_set, hit_rd, hit_clr;
    assign hit_set = set_en && (set_idx == CH_W'(i));
    assign hit_rd  = res_rd && (res_idx == CH_W'(i));
    assign hit_clr = hit_rd && (fast || armed_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccf_q[i]   <= 1'b0;
        armed_q[i] <= 1'b0;
      end else begin
        if (hit_set)      ccf_q[i] <= 1'b1;
        else if (hit_clr) ccf_q[i] <= 1'b0;
        if (hit_rd)                   armed_q[i] <= 1'b0;
        else if (stat_rd && ccf_q[i]) armed_q[i] <= 1'b1;
      end
    end
  end

  assign ccf = ccf_q;

  // R9
  normal_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast && res_rd && ccf_q[res_idx] && !armed_q[res_idx]) |=> ccf_q[$past(res_idx)]);

  // R10
  fast_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && res_rd && !(set_en && set_idx == res_idx)) |=> !ccf_q[$past(res_idx)]);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int SEQ_LEN = 4,
  parameter int REC_CYC = 16,
  localparam int CH_W   = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      ctl_rdata,
  input  logic            stat_rd,
  input  logic            res_rd,
  input  logic [CH_W-1:0] res_idx,
  input  logic            wait_mode,
  input  logic            trig_in,
  input  logic            conv_done,
  input  logic [CH_W-1:0] conv_ch,
  output logic            conv_pwr,
  output logic            seq_start,
  output logic            seq_abort,
  output logic [NCH-1:0]  ccf,
  output logic            suspect,
  output logic            irq
);
  localparam int SC_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  logic [7:1]      ctl_q;
  logic            flag_q, busy_q, halt_q, pend_q, suspect_q;
  logic [SC_W-1:0] cnt_q;
  logic            trig_req, ready, conv_acc, seq_done, halt_now, halt_exit, pend_eff;

  assign halt_now  = ctl_q[CB_PWR] && wait_mode && ctl_q[CB_WOFF];
  assign conv_pwr  = ctl_q[CB_PWR] && !halt_now;
  assign halt_exit = halt_q && !halt_now && ctl_q[CB_PWR];
  assign pend_eff  = pend_q || halt_exit;

  adc_trig_cond u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .enable(ctl_q[CB_TEN]), .level_mode(ctl_q[CB_LVL]), .act_high(ctl_q[CB_POL]),
    .req(trig_req)
  );

  adc_pwr_recov #(.REC_CYC(REC_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_on(conv_pwr), .ready(ready)
  );

  assign seq_start = trig_req && ready && !busy_q && !bus_wr;
  assign seq_abort = bus_wr && busy_q;
  assign conv_acc  = conv_done && busy_q && conv_pwr && !bus_wr;
  assign seq_done  = conv_acc && (cnt_q == SC_W'(SEQ_LEN - 1));

  adc_ccf_bank #(.NCH(NCH), .CH_W(CH_W)) u_ccf (
    .clk(clk), .rst_n(rst_n), .fast(ctl_q[CB_FAST]),
    .set_en(conv_acc), .set_idx(conv_ch),
    .stat_rd(stat_rd), .res_rd(res_rd), .res_idx(res_idx), .ccf(ccf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      flag_q    <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      halt_q    <= 1'b0;
      pend_q    <= 1'b0;
      suspect_q <= 1'b0;
    end else begin
      if (bus_wr) ctl_q <= bus_wdata[7:1];
      if (seq_done)                     flag_q <= 1'b1;
      else if (bus_wr && bus_wdata[0])  flag_q <= 1'b0;
      if (seq_abort || seq_done || !ctl_q[CB_PWR]) busy_q <= 1'b0;
      else if (seq_start)                          busy_q <= 1'b1;
      if (seq_start || seq_abort || seq_done) cnt_q <= '0;
      else if (conv_acc)                      cnt_q <= cnt_q + 1'b1;
      halt_q <= halt_now;
      pend_q <= conv_acc ? 1'b0 : pend_eff;
      if (conv_acc) suspect_q <= pend_eff;
    end
  end

  assign ctl_rdata = {ctl_q, flag_q};
  assign suspect   = suspect_q;
  assign irq       = ctl_q[CB_IEN] && flag_q;

  // R2
  write_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !busy_q);

  // R3
  unpowered_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_pwr |-> !seq_start);

  // R8
  seq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (flag_q && !busy_q));

  // R11
  halt_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_pwr && !bus_wr) |=> $stable(ccf));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> busy_q);

endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/100ps
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       stat_rd = 1'b0, res_rd = 1'b0;
  logic [2:0] res_idx = '0;
  logic       wait_mode = 1'b0, trig_in = 1'b0, conv_done = 1'b0;
  logic [2:0] conv_ch = '0;
  logic       conv_pwr, seq_start, seq_abort, suspect, irq;
  logic [7:0] ccf;

  int nchk = 0, nfail = 0, nstart = 0, nabort = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .ctl_rdata(ctl_rdata), .stat_rd(stat_rd), .res_rd(res_rd), .res_idx(res_idx),
    .wait_mode(wait_mode), .trig_in(trig_in), .conv_done(conv_done), .conv_ch(conv_ch),
    .conv_pwr(conv_pwr), .seq_start(seq_start), .seq_abort(seq_abort), .ccf(ccf),
    .suspect(suspect), .irq(irq)
  );

  always @(negedge clk) begin
    if (seq_start) nstart++;
    if (seq_abort) nabort++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d; tick(); bus_wr = 1'b0;
  endtask

  task automatic done(input logic [2:0] ch);
    conv_done = 1'b1; conv_ch = ch; tick(); conv_done = 1'b0;
  endtask

  task automatic rread(input logic [2:0] ch);
    res_rd = 1'b1; res_idx = ch; tick(); res_rd = 1'b0;
  endtask

  task automatic run_seq();
    for (int c = 0; c < 4; c++) done(3'(c));
  endtask

  task automatic clear_all_fast();
    for (int c = 0; c < 8; c++) rread(3'(c));
  endtask

  task automatic rise_start();
    trig_in = 1'b0; tick(3); trig_in = 1'b1; tick(4);
  endtask

  task automatic t_reset();
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 ccf", ccf, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 pwr", conv_pwr, 0);
    chk("R1 suspect", suspect, 0);
  endtask

  task automatic t_power_enable();
    int n0;
    n0 = nstart;
    wr(8'h0C);
    tick(20); trig_in = 1'b1; tick(5); trig_in = 1'b0; tick(5);
    chk("R3 pwr off", conv_pwr, 0);
    chk("R3 no start", nstart, n0);
    wr(8'h88);
    tick(20); trig_in = 1'b1; tick(5); trig_in = 1'b0; tick(5);
    chk("R5 pwr on", conv_pwr, 1);
    chk("R5 disabled trigger", nstart, n0);
    wr(8'h00); tick(2);
  endtask

  task automatic t_recovery();
    int n0;
    n0 = nstart;
    wr(8'h8C);
    chk("R4 readback", ctl_rdata, 8'h8C);
    trig_in = 1'b1; tick(6); trig_in = 1'b0;
    chk("R4 ignored early", nstart, n0);
    tick(14); trig_in = 1'b1; tick(5);
    chk("R4 start after delay", nstart, n0 + 1);
    run_seq(); tick();
    chk("R8 flag", ctl_rdata[0], 1);
    chk("R8 ccf", ccf, 8'h0F);
  endtask

  task automatic t_edges();
    int n0;
    n0 = nstart;
    trig_in = 1'b0; tick(5);
    chk("R6 rising ignores fall", nstart, n0);
    wr(8'h84); tick(3);
    trig_in = 1'b1; tick(5);
    chk("R6 falling ignores rise", nstart, n0);
    trig_in = 1'b0; tick(5);
    chk("R6 falling start", nstart, n0 + 1);
    run_seq(); tick(5);
    chk("R6 one start per edge", nstart, n0 + 1);
  endtask

  task automatic t_levels();
    int n0;
    n0 = nstart;
    trig_in = 1'b1; tick(3);
    wr(8'h9C); tick(3);
    chk("R7 high start", nstart, n0 + 1);
    run_seq(); tick(2);
    chk("R7 high restart", nstart, n0 + 2);
    trig_in = 1'b0; tick(4); run_seq(); tick(5);
    chk("R7 inactive no start", nstart, n0 + 2);
    n0 = nstart;
    wr(8'h94); tick(3);
    chk("R7 low start", nstart, n0 + 1);
    trig_in = 1'b1; tick(4); run_seq(); tick(5);
    chk("R7 low stops when high", nstart, n0 + 1);
  endtask

  task automatic t_abort();
    int n0, a0;
    wr(8'hCD); clear_all_fast();
    chk("R10 all cleared", ccf, 8'h00);
    rise_start();
    n0 = nstart; a0 = nabort;
    done(3'd0);
    wr(8'hCC); tick();
    chk("R2 abort pulse", nabort, a0 + 1);
    done(3'd1); done(3'd2); done(3'd3); tick(3);
    chk("R2 no start", nstart, n0);
    chk("R2 done ignored", ccf, 8'h01);
    chk("R2 no flag", ctl_rdata[0], 0);
  endtask

  task automatic t_clear_policies();
    wr(8'h8C); rise_start(); run_seq(); tick();
    chk("R8 ccf set", ccf, 8'h0F);
    rread(3'd2); tick();
    chk("R9 no status keeps", ccf, 8'h0F);
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    rread(3'd2); tick();
    chk("R9 status then result", ccf, 8'h0B);
    wr(8'hCC); rread(3'd0); tick();
    chk("R10 fast clear", ccf, 8'h0A);
  endtask

  task automatic t_irq();
    wr(8'hCE); tick();
    chk("R13 irq on", irq, 1);
    wr(8'hCC); tick();
    chk("R13 write 0 keeps flag", ctl_rdata[0], 1);
    wr(8'hCF); tick();
    chk("R13 flag cleared", ctl_rdata[0], 0);
    chk("R13 irq off", irq, 0);
  endtask

  task automatic t_wait();
    wr(8'hEC); clear_all_fast();
    rise_start();
    done(3'd0);
    wait_mode = 1'b1; tick();
    chk("R11 pwr off in wait", conv_pwr, 0);
    done(3'd1);
    wait_mode = 1'b0; tick();
    chk("R11 wait ignored done", ccf, 8'h01);
    done(3'd1);
    chk("R11 first suspect", suspect, 1);
    done(3'd2);
    chk("R11 next good", suspect, 0);
    done(3'd3); tick();
    chk("R11 resumed seq", ccf, 8'h0F);
    chk("R11 flag", ctl_rdata[0], 1);
    wr(8'hCD); clear_all_fast();
    rise_start();
    wait_mode = 1'b1; tick();
    chk("R12 pwr stays", conv_pwr, 1);
    run_seq(); tick();
    chk("R12 ccf", ccf, 8'h0F);
    chk("R12 flag", ctl_rdata[0], 1);
    chk("R12 suspect", suspect, 0);
    wait_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_power_enable();
    t_recovery();
    t_edges();
    t_levels();
    t_abort();
    t_clear_policies();
    t_irq();
    t_wait();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule